// File: doc/BRIEF.md
# Iterative Duty-Cycle Predistortion Cascade

This block turns a stream of modulating samples into corrected PWM duty cycles. A PWM signal built from these duty cycles, once low-pass filtered, should reproduce the modulating signal without in-band distortion. The block is a chain of K identical refinement stages. Stage 0 takes the raw input sample as its first duty estimate. Each stage passes its current estimates through an odd-power Hammerstein model of the filtered PWM output: a static power of the duty value followed by an N-tap FIR filter for each power. It then compares the model output with the input sample, delayed to line up with the model. The estimate is corrected by that error, scaled by a gain that depends on the duty value. The gain approximates 1/sinc(d/2) and is read from a 256-entry table. The last stage's estimate goes to the pulse former, which is outside this block.

Samples enter and leave through valid/ready handshakes. Every accepted input sample moves the whole cascade forward by one sample and loads exactly one result into the output register. The output register holds its value while `out_ready` is low, and the block then refuses new input. The FIR coefficients and the gain table are loaded through a plain write port. This is normally done before streaming starts. The same coefficients and table serve every stage.

Top module: `duty_predistort`

## Requirements
- R1: Duties and inputs are unsigned Q0.16. Every stage builds powers p1=d, sq=(d*d)>>16 and p(2j+1)=(p(2j-1)*sq)>>16, with truncation at each step. The model output is y = (sum over power j and tap m of coef[j][m]*p[j] at tap m) >>> 14, where each coefficient is a signed Q2.14 value. Tap 0 is the newest sample.
- R2: Each stage computes d_next = d_c - ((g * (y - x_c)) >>> 14). d_c is the stage's duty estimate delayed by M=(N-1)/2 samples. g is the unsigned Q2.14 gain table entry indexed by d_c[15:8].
- R3: Every stage clamps its corrected duty to the range 1..65535, so the output never reads 0.
- R4: Stage 0 uses the raw input as its duty estimate. Stage k compares against the input delayed by (k+1)*M samples.
- R5: The result loaded when input sample n is accepted is the duty for sample n-K*M. Histories are zero after reset, so with zero coefficients and gains the first K*M results are 1.
- R6: in_ready is high when out_valid is low or out_ready is high. Each accepted input makes out_valid high on the next cycle. While out_valid is high and out_ready is low, out_duty holds and no input is taken.
- R7: When cfg_we is high, a write to address a<256 sets gain entry a. A write to address 256+j*N+m sets the coefficient of power 2j+1 at tap m. Writes change no output and no sample history.
- R8: Reset clears out_valid, out_duty, all histories, all coefficients and all gain entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Block accepts the input sample this cycle |
| in_data | input | 16 | Modulating sample, unsigned Q0.16 |
| out_valid | output | 1 | out_duty holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_duty | output | 16 | Corrected duty, unsigned Q0.16 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Gain entry (0..255) or coefficient (256+j*N+m) |
| cfg_wdata | input | 16 | Gain (unsigned Q2.14) or coefficient (signed Q2.14) |

## Verification
With all coefficients and gains at zero, the block reduces to a clamped delay line. A ramp with extreme values then exposes the latency of K*M samples and the lower clamp separately from the arithmetic. A loaded table and non-trivial coefficients are then driven with a slow sine, a full-swing square wave and a constant level, and each result is compared with a bit-exact model. The sine stresses the FIR alignment of the centre tap. The square wave drives the cubic term and the gain index to both ends. The constant shows the settled correction. A stalled consumer, writes while idle, and a saturating configuration that forces the upper clamp cover the handshake, the isolation of the write port and the clamp.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int DW        = 16;
  localparam int CW        = 16;
  localparam int FRAC      = 14;
  localparam int TBL_AW    = 8;
  localparam int TBL_DEPTH = 1 << TBL_AW;
  localparam int AW        = 64;
  localparam longint DMAX  = (64'sd1 <<< DW) - 1;

  typedef logic [DW-1:0] duty_t;

  // Q0.16 times Q0.16, truncated back to Q0.16
  function automatic duty_t mulq(input duty_t a, input duty_t b);
    return DW'(({{DW{1'b0}}, a} * {{DW{1'b0}}, b}) >> DW);
  endfunction

  function automatic duty_t clamp_duty(input logic signed [AW-1:0] v);
    if (v < 64'sd1) return DW'(1);
    if (v > DMAX) return DW'(DMAX);
    return DW'(v);
  endfunction
endpackage

// File: rtl/dp_powers.sv
module dp_powers
  import dp_pkg::*;
#(
  parameter int NPOW = 2
) (
  input  duty_t             d,
  output duty_t [NPOW-1:0]  pw
);
  duty_t sq;

  always_comb begin
    sq    = mulq(d, d);
    pw[0] = d;
    for (int j = 1; j < NPOW; j++) pw[j] = mulq(pw[j-1], sq);
  end
endmodule

// File: rtl/dp_cfg.sv
module dp_cfg
  import dp_pkg::*;
#(
  parameter int N      = 5,
  parameter int NPOW   = 2,
  parameter int K      = 3,
  parameter int CFG_AW = 9
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [CFG_AW-1:0]                   addr,
  input  logic [CW-1:0]                       wdata,
  input  logic [K-1:0][TBL_AW-1:0]            rd_idx,
  output logic [K-1:0][CW-1:0]                gain,
  output logic [NPOW-1:0][N-1:0][CW-1:0]      coef
);
  logic [CW-1:0] tbl [TBL_DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_DEPTH; i++) tbl[i] <= '0;
      coef <= '0;
    end else if (we) begin
      if (int'(addr) < TBL_DEPTH) begin
        tbl[addr[TBL_AW-1:0]] <= wdata;
      end else begin
        for (int j = 0; j < NPOW; j++)
          for (int m = 0; m < N; m++)
            if (int'(addr) == TBL_DEPTH + j*N + m) coef[j][m] <= wdata;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < K; k++) gain[k] = tbl[rd_idx[k]];
  end
endmodule

// File: rtl/dp_stage.sv
module dp_stage
  import dp_pkg::*;
#(
  parameter int N    = 5,
  parameter int NPOW = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            adv,
  input  duty_t                           d_in,
  input  duty_t                           x_in,
  input  logic [NPOW-1:0][N-1:0][CW-1:0]  coef,
  input  logic [CW-1:0]                   gain,
  output logic [TBL_AW-1:0]               gain_idx,
  output duty_t                           d_out,
  output duty_t                           x_out
);
  localparam int M = (N - 1) / 2;

  duty_t [NPOW-1:0] pw_now;
  duty_t [NPOW-1:0] hist [N-1];
  duty_t            xh   [M];
  duty_t [NPOW-1:0] tap  [N];
  duty_t            d_c;
  logic signed [AW-1:0] acc, y, err, corr, dn;

  dp_powers #(.NPOW(NPOW)) u_pw (.d(d_in), .pw(pw_now));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N-1; i++) hist[i] <= '0;
      for (int i = 0; i < M; i++) xh[i] <= '0;
    end else if (adv) begin
      hist[0] <= pw_now;
      for (int i = 1; i < N-1; i++) hist[i] <= hist[i-1];
      xh[0] <= x_in;
      for (int i = 1; i < M; i++) xh[i] <= xh[i-1];
    end
  end

  always_comb begin
    tap[0] = pw_now;
    for (int m = 1; m < N; m++) tap[m] = hist[m-1];
    acc = '0;
    for (int j = 0; j < NPOW; j++)
      for (int m = 0; m < N; m++)
        acc = acc + AW'($signed(coef[j][m])) * AW'($signed({1'b0, tap[m][j]}));
    y     = acc >>> FRAC;
    d_c   = hist[M-1][0];
    x_out = xh[M-1];
    err   = y - $signed(AW'(x_out));
    corr  = ($signed(AW'(gain)) * err) >>> FRAC;
    dn    = $signed(AW'(d_c)) - corr;
    d_out = clamp_duty(dn);
  end

  assign gain_idx = d_c[DW-1 -: TBL_AW];
endmodule

// File: rtl/duty_predistort.sv
module duty_predistort
  import dp_pkg::*;
#(
  parameter int N      = 5,
  parameter int P      = 3,
  parameter int K      = 3,
  parameter int CFG_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [15:0]       out_duty,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [15:0]       cfg_wdata
);
  localparam int NPOW = (P + 1) / 2;

  logic                           adv;
  duty_t                          d_chain [K+1];
  duty_t                          x_chain [K+1];
  logic [K-1:0][TBL_AW-1:0]       rd_idx;
  logic [K-1:0][CW-1:0]           gain;
  logic [NPOW-1:0][N-1:0][CW-1:0] coef;

  assign in_ready   = !out_valid || out_ready;
  assign adv        = in_valid && in_ready;
  assign d_chain[0] = in_data;
  assign x_chain[0] = in_data;

  dp_cfg #(.N(N), .NPOW(NPOW), .K(K), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rd_idx(rd_idx), .gain(gain), .coef(coef)
  );

  for (genvar k = 0; k < K; k++) begin : g_stage
    dp_stage #(.N(N), .NPOW(NPOW)) u_stage (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .d_in(d_chain[k]), .x_in(x_chain[k]),
      .coef(coef), .gain(gain[k]), .gain_idx(rd_idx[k]),
      .d_out(d_chain[k+1]), .x_out(x_chain[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_duty  <= '0;
    end else if (adv) begin
      out_valid <= 1'b1;
      out_duty  <= d_chain[K];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dp_checker.sv
module dp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_duty
);
  AST_OUT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_duty != 16'd0); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_duty)); // R6
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R6
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_duty)); // R7
endmodule

bind duty_predistort dp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_duty(out_duty)
);

// File: tb/sim_duty_predistort.sv
module sim_duty_predistort;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5, P = 3, K = 3, CFG_AW = 9;
  localparam int NPOW = (P + 1) / 2;
  localparam int M = (N - 1) / 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1, cfg_we = 0;
  logic in_ready, out_valid;
  logic [15:0] in_data = 0, out_duty, cfg_wdata = 0;
  logic [CFG_AW-1:0] cfg_addr = 0;

  int checks = 0, fails = 0;
  longint coefv [NPOW][N];
  longint gainv [256];
  longint rh [K][N-1][NPOW];
  longint rx [K][M];

  always #(CLK_PERIOD/2) clk = ~clk;

  duty_predistort #(.N(N), .P(P), .K(K), .CFG_AW(CFG_AW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_duty(out_duty), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint clampv(input longint v);
    if (v < 1) return 1;
    if (v > 65535) return 65535;
    return v;
  endfunction

  task automatic ref_clear();
    for (int k = 0; k < K; k++) begin
      for (int m = 0; m < N-1; m++) for (int j = 0; j < NPOW; j++) rh[k][m][j] = 0;
      for (int m = 0; m < M; m++) rx[k][m] = 0;
    end
    for (int j = 0; j < NPOW; j++) for (int m = 0; m < N; m++) coefv[j][m] = 0;
    for (int i = 0; i < 256; i++) gainv[i] = 0;
  endtask

  // bit-exact model of the cascade from R1..R5
  function automatic longint ref_step(input longint x);
    longint d = x, xv = x;
    for (int k = 0; k < K; k++) begin
      longint pw [NPOW];
      longint sq, acc, y, dc, xc, corr, dn, tv;
      pw[0] = d;
      sq = (d * d) >> 16;
      for (int j = 1; j < NPOW; j++) pw[j] = (pw[j-1] * sq) >> 16;
      acc = 0;
      for (int j = 0; j < NPOW; j++)
        for (int m = 0; m < N; m++) begin
          tv = (m == 0) ? pw[j] : rh[k][m-1][j];
          acc += coefv[j][m] * tv;
        end
      y = acc >>> 14;
      dc = rh[k][M-1][0];
      xc = rx[k][M-1];
      corr = (gainv[dc >> 8] * (y - xc)) >>> 14;
      dn = clampv(dc - corr);
      for (int m = N-2; m > 0; m--) for (int j = 0; j < NPOW; j++) rh[k][m][j] = rh[k][m-1][j];
      for (int j = 0; j < NPOW; j++) rh[k][0][j] = pw[j];
      for (int m = M-1; m > 0; m--) rx[k][m] = rx[k][m-1];
      rx[k][0] = xv;
      d = dn;
      xv = xc;
    end
    return d;
  endfunction

  task automatic cfg_write(input int a, input longint v);
    cfg_we = 1; cfg_addr = CFG_AW'(a); cfg_wdata = 16'(v);
    @(negedge clk);
    cfg_we = 0;
    if (a < 256) gainv[a] = v & 16'hFFFF;
    else coefv[(a-256)/N][(a-256)%N] = longint'($signed(16'(v)));
  endtask

  // called at a negedge; drives one sample, checks the result at the next negedge
  task automatic push_ref(input string tag, input int x);
    longint e;
    in_valid = 1; in_data = 16'(x);
    @(negedge clk);
    e = ref_step(x);
    chk(tag, out_duty, e);
  endtask

  task automatic t_reset();
    chk("R8 out_valid after reset", out_valid, 0);
    chk("R8 out_duty after reset", out_duty, 0);
    chk("R6 in_ready while empty", in_ready, 1);
  endtask

  task automatic t_identity();
    int seq [12] = '{0, 100, 40000, 65535, 32768, 7, 1234, 50000, 0, 9, 9, 9};
    for (int i = 0; i < 12; i++) begin
      longint e = (i < K*M) ? 1 : clampv(seq[i-K*M]);
      in_valid = 1; in_data = 16'(seq[i]);
      @(negedge clk);
      void'(ref_step(seq[i]));
      chk($sformatf("R5 R3 R8 pure delay sample %0d", i), out_duty, e);
    end
    chk("R6 out_valid after accept", out_valid, 1);
    in_valid = 0;
  endtask

  task automatic t_cfg_quiet();
    logic [15:0] held = out_duty;
    cfg_write(0, 16'h1234);
    cfg_write(256 + 2, 16'h0100);
    chk("R7 output untouched by config writes", out_duty, held);
    chk("R6 out_valid drops when drained", out_valid, 0);
  endtask

  task automatic load_config();
    int h1 [N] = '{-300, 1200, 15800, 1200, -300};
    int h3 [N] = '{40, -500, 900, -500, 40};
    for (int i = 0; i < 256; i++) begin
      real dd = (i + 0.5) / 256.0;
      real u = 3.14159265358979 * dd / 2.0;
      cfg_write(i, $rtoi(16384.0 * u / $sin(u) + 0.5));
    end
    for (int m = 0; m < N; m++) cfg_write(256 + m, h1[m]);
    for (int m = 0; m < N; m++) cfg_write(256 + N + m, h3[m]);
  endtask

  task automatic t_sine();
    for (int i = 0; i < 40; i++)
      push_ref("R1 R2 R4 sine vs model",
               $rtoi(32768.0 + 30000.0 * $sin(6.2831853 * i / 16.0)));
    in_valid = 0;
  endtask

  task automatic t_square();
    for (int i = 0; i < 20; i++) push_ref("R1 R2 R4 square vs model", (i % 2) ? 62000 : 3000);
    in_valid = 0;
  endtask

  task automatic t_const();
    for (int i = 0; i < 20; i++) push_ref("R1 R2 constant vs model", 32768);
    in_valid = 0;
  endtask

  task automatic t_backpressure();
    longint ea, eb;
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_data = 16'd20000;
    @(negedge clk);
    ea = ref_step(20000);
    chk("R6 first result under stall", out_duty, ea);
    chk("R6 out_valid under stall", out_valid, 1);
    in_data = 16'd45000;
    for (int i = 0; i < 3; i++) begin
      chk("R6 in_ready low while stalled", in_ready, 0);
      @(negedge clk);
      chk("R6 out_duty held while stalled", out_duty, ea);
    end
    out_ready = 1;
    @(negedge clk);
    eb = ref_step(45000);
    chk("R6 held sample accepted after release", out_duty, eb);
    in_valid = 0;
  endtask

  task automatic t_clamp_high();
    for (int m = 0; m < N; m++) begin
      cfg_write(256 + m, 0);
      cfg_write(256 + N + m, 0);
    end
    for (int i = 0; i < 256; i++) cfg_write(i, 16'hFFFF);
    for (int i = 0; i < 12; i++) push_ref("R2 R3 saturating config vs model", 60000);
    chk("R3 upper clamp", out_duty, 65535);
    in_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ref_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_cfg_quiet();
    ref_clear();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    load_config();
    t_sine();
    t_square();
    t_const();
    t_backpressure();
    t_clamp_high();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule